// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Bus Interface

This block is the digital side of a 12-bit successive-approximation converter that sits on a microprocessor bus. Three bus control inputs (chip enable, active-low chip select and a read/convert select) start conversions and open the data bus for reads. A byte-address input and a word/byte format input pick the conversion length and how the result is laid onto the bus. The block does not contain the analog parts. It presents a trial code to an external DAC, reads back a single comparator bit, and settles one result bit per clock, starting at the MSB.

A conversion starts on the clock in which the combined start term first becomes true. Any of the three control inputs can be the one that completes the term. The byte-address value captured at that point selects a full 12-bit conversion or a short 8-bit one. While the converter is busy, the control inputs cannot abort or restart the conversion. However, a fresh start edge during a conversion captures the byte-address input again, and that can change the length of the conversion already running. The busy output is high only while a conversion runs. The data bus is enabled only for a read of an idle converter.

Top module: `sar_bus_ctrl`

## Requirements
- R1: The start term is ce_i=1, cs_n_i=0, rc_i=0. When this term is sampled true at a clock edge after being false at the previous edge, busy_o is high from that edge on. This holds whichever of the three inputs completed the term.
- R2: If all three control inputs reach the start term in the same cycle, the conversion starts with the same one-edge latency as in R1.
- R3: If ao_i=0 at the start edge, busy_o stays high for exactly 12 clock cycles and all 12 result bits are resolved. If ao_i=1, busy_o stays high for 8 cycles and result bits [3:0] are zero.
- R4: dac_code_o shows the trial code. Bits already decided keep their values, the bit under test is 1 and lower bits are 0. The first trial is 0x800. cmp_i=1 means the input is at or above the trial, and the bit is then kept. The result is the straight binary code of the input.
- R5: During a conversion, control transitions neither abort it nor restart it. The length and the result are those of the uninterrupted conversion.
- R6: A start edge during a conversion captures ao_i again, and the new length takes effect from the next cycle. For example, a 12-bit conversion switched to short before bit 4 ends after 8 cycles, and its low 4 bits are cleared.
- R7: busy_o is low out of reset and whenever no conversion runs. It falls at the same edge that writes the final result bit.
- R8: bus_oe_o is 1 only when rc_i=1, ce_i=1, cs_n_i=0 and busy_o=0. While bus_oe_o is 0, bus_data_o is all zeros.
- R9: When reading, the bus layout is as follows. With fmt12_i=1, bus_data_o = result[11:0]. With fmt12_i=0 and ao_i=0, bus_data_o[11:4] = result[11:4] and [3:0] = 0. With fmt12_i=0 and ao_i=1, bus_data_o[11:8] = result[3:0] and [7:0] = 0.
- R10: After reset, the result, dac_code_o and bus_oe_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read (1) or convert (0) select |
| ao_i | input | 1 | Byte address; short-conversion select at start |
| fmt12_i | input | 1 | Word read (1) or byte read (0) |
| cmp_i | input | 1 | Comparator: input at or above trial code |
| dac_code_o | output | 12 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| bus_data_o | output | 12 | Data for the three-state bus pads |
| bus_oe_o | output | 1 | Enable for the bus pad drivers |

## Verification
On every cycle, the assertions check the following:
- the bus stays disabled and zeroed while the converter is busy;
- a start from idle raises busy with the MSB under test;
- a conversion never ends before its last bit;
- the result holds while idle;
- a short conversion leaves its low nibble clear;
- no conversion outlasts 12 cycles.

Only the bench scenarios can show the rest. These are:
- the exact busy length for each latched length;
- the correctness of the binary search against a modelled input;
- which input completes the start;
- the re-capture of the byte address in mid-conversion;
- the three bus layouts of a read.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;
   typedef enum logic [1:0] {
      RD_WORD = 2'd0,
      RD_HIGH = 2'd1,
      RD_LOW  = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_i,
   input  logic cs_n_i,
   input  logic rc_i,
   output logic start_pulse_o
);
   logic term;
   logic term_prev_q;

   assign term = ce_i & ~cs_n_i & ~rc_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) term_prev_q <= 1'b0;
      else        term_prev_q <= term;
   end

   assign start_pulse_o = term & ~term_prev_q;

   // R1: a pulse is never two cycles long
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse_o |=> !start_pulse_o);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ao_i,
   input  logic             cmp_i,
   output logic [RES_W-1:0] trial_o,
   output logic [RES_W-1:0] result_o,
   output logic             busy_o
);
   localparam int IDX_W = $clog2(RES_W);
   localparam int LOW_W = RES_W - SHORT_W;
   localparam int CNT_W = $clog2(RES_W + 1) + 1;
   localparam logic [RES_W-1:0] LOW_MASK = RES_W'((1 << LOW_W) - 1);
   localparam logic [RES_W-1:0] MSB_BIT  = RES_W'(1) << (RES_W - 1);

   logic             busy_q;
   logic             short_q;
   logic [IDX_W-1:0] idx_q;
   logic [RES_W-1:0] trial_q;
   logic [RES_W-1:0] result_q;
   logic [RES_W-1:0] bit_mask;
   logic [RES_W-1:0] decided;
   logic [RES_W-1:0] keep_mask;
   logic             last_bit;

   assign bit_mask  = RES_W'(1) << idx_q;
   assign decided   = (trial_q & ~bit_mask) | (cmp_i ? bit_mask : '0);
   assign keep_mask = short_q ? ~LOW_MASK : '1;
   assign last_bit  = short_q ? (idx_q <= IDX_W'(LOW_W)) : (idx_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         short_q  <= 1'b0;
         idx_q    <= '0;
         trial_q  <= '0;
         result_q <= '0;
      end else begin
         if (start_i) short_q <= ao_i;
         if (!busy_q) begin
            if (start_i) begin
               busy_q  <= 1'b1;
               idx_q   <= IDX_W'(RES_W - 1);
               trial_q <= MSB_BIT;
            end
         end else if (last_bit) begin
            busy_q   <= 1'b0;
            result_q <= decided & keep_mask;
            trial_q  <= decided & keep_mask;
         end else begin
            trial_q <= decided | (bit_mask >> 1);
            idx_q   <= idx_q - 1'b1;
         end
      end
   end

   assign trial_o  = trial_q;
   assign result_o = result_q;
   assign busy_o   = busy_q;

   logic [CNT_W-1:0] busy_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt_q <= '0;
      else if (busy_q) busy_cnt_q <= busy_cnt_q + 1'b1;
      else             busy_cnt_q <= '0;
   end

   a_r1_start_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_q) |=> (busy_q && trial_q == MSB_BIT));
   a_r5_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last_bit) |=> busy_q);
   a_r3_short_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && last_bit && short_q) |=> ((result_q & LOW_MASK) == '0));
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start_i) |=> (!busy_q && $stable(result_q)));
   a_r3_max_len: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt_q <= CNT_W'(RES_W));
endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux
   import sar_bus_pkg::*;
#(
   parameter int RES_W     = 12,
   parameter int SHORT_W   = 8,
   parameter bit BYTE_READ = 1'b1
) (
   input  logic             rd_en_i,
   input  logic             fmt12_i,
   input  logic             ao_i,
   input  logic [RES_W-1:0] result_i,
   output logic [RES_W-1:0] data_o
);
   localparam int LOW_W = RES_W - SHORT_W;

   rd_sel_e          sel;
   logic [RES_W-1:0] word;

   assign sel = fmt12_i ? RD_WORD : (ao_i ? RD_LOW : RD_HIGH);

   generate
      if (BYTE_READ) begin : g_byte
         always_comb begin
            word = '0;
            unique case (sel)
               RD_WORD: word = result_i;
               RD_HIGH: word[RES_W-1 -: SHORT_W] = result_i[RES_W-1 -: SHORT_W];
               RD_LOW:  word[RES_W-1 -: LOW_W]   = result_i[LOW_W-1:0];
               default: word = '0;
            endcase
         end
      end else begin : g_word
         assign word = result_i;
      end
   endgenerate

   assign data_o = rd_en_i ? word : '0;
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
   parameter int RES_W     = 12,
   parameter int SHORT_W   = 8,
   parameter bit BYTE_READ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_i,
   input  logic             cs_n_i,
   input  logic             rc_i,
   input  logic             ao_i,
   input  logic             fmt12_i,
   input  logic             cmp_i,
   output logic [RES_W-1:0] dac_code_o,
   output logic             busy_o,
   output logic [RES_W-1:0] bus_data_o,
   output logic             bus_oe_o
);
   generate
      if (SHORT_W < 1 || SHORT_W >= RES_W) begin : g_bad_short
         $error("SHORT_W must lie between 1 and RES_W-1");
      end
      if (RES_W - SHORT_W > SHORT_W) begin : g_bad_low
         $error("low part must fit in the short byte");
      end
   endgenerate

   logic             start_pulse;
   logic [RES_W-1:0] result;
   logic             busy;
   logic             rd_en;

   sar_start_detect u_start (
      .clk           (clk),
      .rst_n         (rst_n),
      .ce_i          (ce_i),
      .cs_n_i        (cs_n_i),
      .rc_i          (rc_i),
      .start_pulse_o (start_pulse)
   );

   sar_sequencer #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_pulse),
      .ao_i     (ao_i),
      .cmp_i    (cmp_i),
      .trial_o  (dac_code_o),
      .result_o (result),
      .busy_o   (busy)
   );

   assign rd_en = rc_i & ce_i & ~cs_n_i & ~busy;

   sar_bus_mux #(.RES_W(RES_W), .SHORT_W(SHORT_W), .BYTE_READ(BYTE_READ)) u_mux (
      .rd_en_i  (rd_en),
      .fmt12_i  (fmt12_i),
      .ao_i     (ao_i),
      .result_i (result),
      .data_o   (bus_data_o)
   );

   assign busy_o   = busy;
   assign bus_oe_o = rd_en;

   a_r8_hiz_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !bus_oe_o);
   a_r8_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_o |-> (bus_data_o == '0));
endmodule

// File: tb/sar_bus_ctrl_bench.sv
module sar_bus_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce = 1'b0, cs_n = 1'b1, rc = 1'b1, ao = 1'b0, fmt12 = 1'b1;
   logic [11:0] dac, bus;
   logic        busy, oe, cmp;
   int          vin = 0;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   assign cmp = (vin >= int'(dac));

   sar_bus_ctrl u_sar_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc),
      .ao_i(ao), .fmt12_i(fmt12), .cmp_i(cmp), .dac_code_o(dac),
      .busy_o(busy), .bus_data_o(bus), .bus_oe_o(oe));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      ce = 1'b0; cs_n = 1'b1; rc = 1'b1;
      @(negedge clk);
   endtask

   // mode 0 plain, 1 re-latch short, 2 abort attempt, 3 read attempt
   task automatic run_conv(input int mode, output int len, output int d0,
                           output int d1, output int d2);
      len = 0; d0 = 0; d1 = 0; d2 = 0;
      forever begin
         @(negedge clk);
         if (!busy) break;
         len++;
         if (len == 1) d0 = dac;
         if (len == 2) d1 = dac;
         if (len == 3) d2 = dac;
         if (mode == 1 && len == 3) rc = 1'b1;
         if (mode == 1 && len == 4) begin ao = 1'b1; rc = 1'b0; end
         if (mode == 2 && len == 3) begin ce = 1'b0; cs_n = 1'b1; end
         if (mode == 2 && len == 5) begin ce = 1'b1; cs_n = 1'b0; end
         if (mode == 3 && len == 4) rc = 1'b1;
         if (mode == 3 && len == 5) chk("R8 oe during busy", int'(oe), 0);
         if (len > 40) break;
      end
   endtask

   task automatic read_word(output int w);
      @(negedge clk);
      ce = 1'b1; cs_n = 1'b0; rc = 1'b1; fmt12 = 1'b1;
      #2 w = int'(bus);
      chk("R8 oe on read", int'(oe), 1);
   endtask

   task automatic t_reset();
      chk("R10 busy", int'(busy), 0);
      chk("R10 dac", int'(dac), 0);
      chk("R10 oe", int'(oe), 0);
      chk("R8 bus zero", int'(bus), 0);
      begin int w; read_word(w); chk("R10 result", w, 0); end
      go_idle();
   endtask

   // which: 0 ce last, 1 cs last, 2 rc last, 3 all together
   task automatic t_start(input int which, input int v);
      int len, d0, d1, d2, w;
      vin = v; ao = 1'b0;
      @(negedge clk);
      ce = (which == 0 || which == 3) ? 1'b0 : 1'b1;
      cs_n = (which == 1 || which == 3) ? 1'b1 : 1'b0;
      rc = 1'b0;
      if (which == 2) rc = 1'b1;
      if (which == 3) rc = 1'b1;
      @(negedge clk);
      ce = 1'b1; cs_n = 1'b0; rc = 1'b0;
      #2 chk("R1 no busy before edge", int'(busy), 0);
      run_conv(0, len, d0, d1, d2);
      chk(which == 3 ? "R2 len" : "R1 len", len, 12);
      chk("R7 busy low after", int'(busy), 0);
      chk("R4 dac msb trial", d0, 'h800);
      chk("R4 dac 2nd", d1, ((v & 'h800) | 'h400));
      chk("R4 dac 3rd", d2, ((v & 'hC00) | 'h200));
      read_word(w);
      chk("R3 12-bit result", w, v);
      go_idle();
   endtask

   task automatic t_short(input int v);
      int len, d0, d1, d2, w;
      vin = v;
      @(negedge clk);
      ao = 1'b1; ce = 1'b1; cs_n = 1'b0; rc = 1'b0;
      run_conv(0, len, d0, d1, d2);
      chk("R3 short len", len, 8);
      read_word(w);
      chk("R3 short result", w, v & 'hFF0);
      go_idle();
   endtask

   task automatic t_relatch(input int v);
      int len, d0, d1, d2, w;
      vin = v;
      @(negedge clk);
      ao = 1'b0; ce = 1'b1; cs_n = 1'b0; rc = 1'b0;
      run_conv(1, len, d0, d1, d2);
      chk("R6 relatched len", len, 8);
      read_word(w);
      chk("R6 relatched result", w, v & 'hFF0);
      go_idle();
   endtask

   task automatic t_noabort(input int v, input int mode);
      int len, d0, d1, d2, w;
      vin = v;
      @(negedge clk);
      ao = 1'b0; ce = 1'b1; cs_n = 1'b0; rc = 1'b0;
      run_conv(mode, len, d0, d1, d2);
      chk("R5 len unchanged", len, 12);
      read_word(w);
      chk("R5 result unchanged", w, v);
      go_idle();
   endtask

   task automatic t_layout(input int v);
      @(negedge clk);
      ce = 1'b1; cs_n = 1'b0; rc = 1'b1; fmt12 = 1'b0; ao = 1'b0;
      #2 chk("R9 high byte", int'(bus), v & 'hFF0);
      @(negedge clk);
      ao = 1'b1;
      #2 chk("R9 low nibble", int'(bus), (v & 'hF) << 8);
      @(negedge clk);
      cs_n = 1'b1;
      #2 chk("R8 deselected", int'(oe), 0);
      chk("R8 deselected zero", int'(bus), 0);
      @(negedge clk);
      cs_n = 1'b0; ce = 1'b0;
      #2 chk("R8 ce low", int'(oe), 0);
      fmt12 = 1'b1;
      go_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_start(0, 'hA5C);
      t_start(1, 'h000);
      t_start(2, 'hFFF);
      t_start(3, 'h7C3);
      t_short('h3B7);
      t_relatch('hD29);
      t_noabort('h5E1, 2);
      t_noabort('h9A6, 3);
      t_start(0, 'hC4B);
      t_layout('hC4B);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule